// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one analog-to-digital conversion from the peripheral clock. A conversion begins on a software start pulse or on a selected edge of an external trigger pin. The length of the conversion window comes from a 3-bit time-select code. A power-mode input decides whether a settling phase runs first, with its own length taken from the same code, and whether the comparator stays powered while the converter waits.

The sequencer drives a comparator-enable line and a conversion-window strobe for the successive-approximation logic next to it. At the end of the window it gives a one-cycle done pulse and then goes back to waiting. One select code is reserved. The block raises an error flag for it and will not start while that code is applied. Dropping the enable input stops a running sequence at once, and no done pulse follows.

Top module: `adc_seq_top`

## Requirements
- R1: With power mode 0, a start gives a conversion window (conv_win high) that lasts exactly 168, 120, 84, 60, 48, 36 or 12 cycles for time_sel codes 000, 001, 010, 011, 100, 101 and 111. The window begins in the cycle after the clock edge that samples the start.
- R2: With power mode 1, a settling phase of 64, 60, 42, 30, 24, 18 or 6 cycles (same code order as R1) runs before the window. During it comp_en is high and conv_win is low. With power mode 0 no settling phase occurs.
- R3: While the sequencer is idle, whether enable is low or high, comp_en equals the inverse of pwr_save. During the settling and conversion phases comp_en is 1.
- R4: time_sel = 110 is reserved. sel_err is 1 from the cycle after that code is applied, and 0 the cycle after any other code is applied. While the code is held, no start is accepted and done never rises.
- R5: edge_sel selects which edges of ext_trig start a conversion. 00 starts on no edge, 01 on falling edges only, 10 on rising edges only, and 11 on both. The pin passes through a two-stage synchronizer first.
- R6: A trigger edge or a software start that arrives while a sequence is running is ignored. It does not start a second conversion afterwards.
- R7: done is high for exactly one cycle, in the cycle right after the last conv_win cycle. The sequencer is idle in that cycle.
- R8: Taking enable low during a sequence returns the sequencer to idle at the next clock edge. conv_win drops and no done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter run enable; low aborts and holds idle |
| sw_start | input | 1 | Software start request, sampled while idle |
| time_sel | input | 3 | Conversion-time select code |
| pwr_save | input | 1 | 1 = settling phase on and comparator off while idle |
| edge_sel | input | 2 | External trigger edge select |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| comp_en | output | 1 | Comparator power enable |
| conv_win | output | 1 | High during the conversion phase |
| done | output | 1 | One-cycle pulse at the end of a conversion |
| sel_err | output | 1 | Reserved time code is applied |

## Verification
On every cycle the assertions check four things. The phase counter stays within the longest table entry. done never lasts past one cycle and only follows the conversion phase. A reserved code keeps the sequencer idle. A low enable forces idle at the next edge. The exact phase lengths for each code can only be shown by the bench scenarios, as can the edge filtering for each edge_sel value, the comparator power rule while idle, and the rejection of starts that arrive mid-sequence. The bench measures these at the ports.

// File: rtl/adc_seq_pkg.sv
// Shared types and constants for the ADC conversion timing sequencer.
// Assumes a counter width that can hold the longest phase length.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STAB = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

    localparam logic [2:0] SEL_RSVD  = 3'b110;
    localparam int         MAX_LEN   = 168;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;
    localparam logic [1:0] EDGE_RISE = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/adc_trig_sync.sv
// Synchronises the external trigger pin and turns the selected edges into
// one-cycle start pulses. Assumes the pin is low while reset is applied.
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       pulse_o
);
    import adc_seq_pkg::*;

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              rise_w;
    logic              fall_w;

    // Shift the pin through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_w = chain_q[STAGES-1] & ~last_q;
    assign fall_w = ~chain_q[STAGES-1] & last_q;

    // Choose which synchronised edges count as a start.
    always_comb begin
        case (edge_sel_i)
            EDGE_FALL: pulse_o = fall_w;
            EDGE_RISE: pulse_o = rise_w;
            EDGE_BOTH: pulse_o = rise_w | fall_w;
            default:   pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_len_decode.sv
// Maps a time-select code to its conversion and settling cycle counts.
// The reserved code returns zero lengths. The caller must refuse it.
module adc_len_decode #(
    parameter int CNT_W = 8
) (
    input  logic [2:0]       sel_i,
    output logic [CNT_W-1:0] conv_len_o,
    output logic [CNT_W-1:0] stab_len_o
);
    // Look up the length pair for the code.
    always_comb begin
        case (sel_i)
            3'b000:  begin conv_len_o = CNT_W'(168); stab_len_o = CNT_W'(64); end
            3'b001:  begin conv_len_o = CNT_W'(120); stab_len_o = CNT_W'(60); end
            3'b010:  begin conv_len_o = CNT_W'(84);  stab_len_o = CNT_W'(42); end
            3'b011:  begin conv_len_o = CNT_W'(60);  stab_len_o = CNT_W'(30); end
            3'b100:  begin conv_len_o = CNT_W'(48);  stab_len_o = CNT_W'(24); end
            3'b101:  begin conv_len_o = CNT_W'(36);  stab_len_o = CNT_W'(18); end
            3'b111:  begin conv_len_o = CNT_W'(12);  stab_len_o = CNT_W'(6);  end
            default: begin conv_len_o = '0;          stab_len_o = '0;         end
        endcase
    end
endmodule

// File: rtl/adc_phase_fsm.sv
// Runs the idle / settling / conversion phases using a single down-counter.
// It latches the select code at the start and gates comparator power by
// mode while idle. Assumes the length inputs follow lookup_sel_o.
module adc_phase_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             start_i,
    input  logic             pwr_save_i,
    input  logic [2:0]       sel_i,
    input  logic [CNT_W-1:0] conv_len_i,
    input  logic [CNT_W-1:0] stab_len_i,
    output logic [2:0]       lookup_sel_o,
    output logic             comp_en_o,
    output logic             conv_win_o,
    output logic             done_o,
    output logic             sel_err_o
);
    import adc_seq_pkg::*;

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       sel_q;
    logic             done_q;
    logic             err_q;
    logic             rsvd_w;

    assign rsvd_w = (sel_i == SEL_RSVD);

    // Look up the live code while idle and the latched code while busy.
    assign lookup_sel_o = (state_q == ST_IDLE) ? sel_i : sel_q;

    // Phase sequencing, counting down, and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!enable_i) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_i && !rsvd_w) begin
                            sel_q <= sel_i;
                            if (pwr_save_i) begin
                                state_q <= ST_STAB;
                                cnt_q   <= stab_len_i - 1'b1;
                            end else begin
                                state_q <= ST_CONV;
                                cnt_q   <= conv_len_i - 1'b1;
                            end
                        end
                    end
                    ST_STAB: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_CONV;
                            cnt_q   <= conv_len_i - 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    ST_CONV: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Register the reserved-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= rsvd_w;
    end

    assign comp_en_o  = (state_q == ST_IDLE) ? ~pwr_save_i : 1'b1;
    assign conv_win_o = (state_q == ST_CONV);
    assign done_o     = done_q;
    assign sel_err_o  = err_q;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_LEN - 1));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    done_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) == ST_CONV && state_q == ST_IDLE));

    // R4
    rsvd_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rsvd_w) |=> state_q == ST_IDLE);

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/adc_seq_top.sv
// Top of the ADC conversion timing sequencer. Combines the trigger
// synchroniser, the length decoder and the phase controller. Assumes a
// single clock and a synchronous active-low reset.
module adc_seq_top #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sw_start,
    input  logic [2:0] time_sel,
    input  logic       pwr_save,
    input  logic [1:0] edge_sel,
    input  logic       ext_trig,
    output logic       comp_en,
    output logic       conv_win,
    output logic       done,
    output logic       sel_err
);
    logic             trig_pulse;
    logic [2:0]       lookup_sel;
    logic [CNT_W-1:0] conv_len;
    logic [CNT_W-1:0] stab_len;
    logic             start_req;

    adc_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_trig),
        .edge_sel_i (edge_sel),
        .pulse_o    (trig_pulse)
    );

    adc_len_decode #(.CNT_W(CNT_W)) i_dec (
        .sel_i      (lookup_sel),
        .conv_len_o (conv_len),
        .stab_len_o (stab_len)
    );

    assign start_req = sw_start | trig_pulse;

    adc_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable),
        .start_i      (start_req),
        .pwr_save_i   (pwr_save),
        .sel_i        (time_sel),
        .conv_len_i   (conv_len),
        .stab_len_i   (stab_len),
        .lookup_sel_o (lookup_sel),
        .comp_en_o    (comp_en),
        .conv_win_o   (conv_win),
        .done_o       (done),
        .sel_err_o    (sel_err)
    );
endmodule

// File: tb/test_adc_seq_top.sv
// Directed bench for the ADC conversion timing sequencer.
module test_adc_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sw_start = 1'b0;
    logic [2:0] time_sel = 3'b111;
    logic       pwr_save = 1'b1;
    logic [1:0] edge_sel = 2'b00;
    logic       ext_trig = 1'b0;
    logic       comp_en, conv_win, done, sel_err;

    int n_chk = 0;
    int n_fail = 0;
    int starts = 0;
    int dones = 0;
    bit prev_cw = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_seq_top i_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sw_start(sw_start),
        .time_sel(time_sel), .pwr_save(pwr_save), .edge_sel(edge_sel),
        .ext_trig(ext_trig), .comp_en(comp_en), .conv_win(conv_win),
        .done(done), .sel_err(sel_err)
    );

    // Count conversion starts and done pulses away from the active edge.
    always @(negedge clk) begin
        if (conv_win && !prev_cw) starts++;
        if (done) dones++;
        prev_cw = conv_win;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1 R2 R7: software start, then measure the phase lengths and the done timing.
    task automatic run_sw(input logic [2:0] sel, input logic ps, input int exp_st, input int exp_cv);
        int st = 0, cv = 0, dn = 0, dn_at = -1;
        time_sel = sel; pwr_save = ps;
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (conv_win) cv++;
            else if (cv == 0 && comp_en) st++;
            if (done) begin dn++; if (dn_at < 0) dn_at = i; end
            @(negedge clk);
        end
        chk(st == exp_st, ps ? "R2 settling length" : "R2 no settling", st, exp_st);
        chk(cv == exp_cv, "R1 conversion length", cv, exp_cv);
        chk(dn == 1, "R7 single done", dn, 1);
        chk(dn_at == exp_st + exp_cv, "R7 done cycle", dn_at, exp_st + exp_cv);
    endtask

    task automatic test_reset;
        chk(conv_win == 1'b0, "R3 reset conv_win", conv_win, 0);
        chk(done == 1'b0, "R7 reset done", done, 0);
        chk(comp_en == 1'b0, "R3 reset comp_en ps=1", comp_en, 0);
        chk(sel_err == 1'b0, "R4 reset sel_err", sel_err, 0);
    endtask

    task automatic test_idle_power;
        enable = 1'b0; pwr_save = 1'b0; wait_cyc(2);
        chk(comp_en == 1'b1, "R3 stopped ps=0", comp_en, 1);
        pwr_save = 1'b1; wait_cyc(2);
        chk(comp_en == 1'b0, "R3 stopped ps=1", comp_en, 0);
        enable = 1'b1; wait_cyc(2);
        chk(comp_en == 1'b0, "R3 idle ps=1", comp_en, 0);
        pwr_save = 1'b0; wait_cyc(2);
        chk(comp_en == 1'b1, "R3 idle ps=0", comp_en, 1);
    endtask

    task automatic test_reserved;
        int s0, d0;
        time_sel = 3'b110; pwr_save = 1'b0; wait_cyc(2);
        chk(sel_err == 1'b1, "R4 flag set", sel_err, 1);
        s0 = starts; d0 = dones;
        sw_start = 1'b1; wait_cyc(3); sw_start = 1'b0;
        wait_cyc(60);
        chk(starts == s0, "R4 no start", starts - s0, 0);
        chk(dones == d0, "R4 no done", dones - d0, 0);
        time_sel = 3'b111; wait_cyc(2);
        chk(sel_err == 1'b0, "R4 flag clear", sel_err, 0);
    endtask

    // R5: try one edge_sel value with a rising then a falling pin edge.
    task automatic edge_try(input logic [1:0] es, input int exp_r, input int exp_f);
        int s0;
        edge_sel = es; time_sel = 3'b111; pwr_save = 1'b0; wait_cyc(4);
        s0 = starts; ext_trig = 1'b1; wait_cyc(30);
        chk(starts - s0 == exp_r, "R5 rising edge", starts - s0, exp_r);
        s0 = starts; ext_trig = 1'b0; wait_cyc(30);
        chk(starts - s0 == exp_f, "R5 falling edge", starts - s0, exp_f);
    endtask

    task automatic test_busy_ignore;
        int s0, d0;
        edge_sel = 2'b11; time_sel = 3'b000; pwr_save = 1'b0;
        s0 = starts; d0 = dones;
        @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        wait_cyc(10); ext_trig = 1'b1; wait_cyc(10); ext_trig = 1'b0;
        wait_cyc(10); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        wait_cyc(200);
        chk(starts - s0 == 1, "R6 busy starts ignored", starts - s0, 1);
        chk(dones - d0 == 1, "R6 one done only", dones - d0, 1);
        edge_sel = 2'b00;
    endtask

    task automatic test_abort;
        int d0;
        time_sel = 3'b000; pwr_save = 1'b0; d0 = dones;
        @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        wait_cyc(20);
        chk(conv_win == 1'b1, "R8 running before abort", conv_win, 1);
        enable = 1'b0; @(negedge clk);
        chk(conv_win == 1'b0, "R8 window dropped", conv_win, 0);
        wait_cyc(200);
        chk(dones == d0, "R8 no done", dones - d0, 0);
        enable = 1'b1; wait_cyc(5);
        chk(conv_win == 1'b0, "R8 stays idle", conv_win, 0);
    endtask

    initial begin
        wait_cyc(3);
        test_reset;
        rst_n = 1'b1; wait_cyc(2);
        test_idle_power;
        run_sw(3'b000, 1'b0, 0, 168);
        run_sw(3'b001, 1'b0, 0, 120);
        run_sw(3'b010, 1'b0, 0, 84);
        run_sw(3'b011, 1'b0, 0, 60);
        run_sw(3'b100, 1'b0, 0, 48);
        run_sw(3'b101, 1'b0, 0, 36);
        run_sw(3'b111, 1'b0, 0, 12);
        run_sw(3'b000, 1'b1, 64, 168);
        run_sw(3'b001, 1'b1, 60, 120);
        run_sw(3'b010, 1'b1, 42, 84);
        run_sw(3'b011, 1'b1, 30, 60);
        run_sw(3'b100, 1'b1, 24, 48);
        run_sw(3'b101, 1'b1, 18, 36);
        run_sw(3'b111, 1'b1, 6, 12);
        test_reserved;
        edge_try(2'b00, 0, 0);
        edge_try(2'b01, 0, 1);
        edge_try(2'b10, 1, 0);
        edge_try(2'b11, 1, 1);
        test_busy_ignore;
        test_abort;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait_cyc(100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule